// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to 64 level-sensitive interrupt requests and presents the most urgent one to a processor. It drives one of two processor lines: a fast line or a normal line. Each source holds a 4-bit priority, and a priority of zero switches the source off. A 16-bit routing word chooses, for each priority level rather than for each source, which of the two lines that level drives.

Software talks to the block over a small synchronous register bus. Reading the acknowledge register returns the vector of the winning source. The same read raises the current masking level to the level of that source, so requests at or below it stop interrupting. Writing the end-of-interrupt register brings back the level that was in force before. Two saved levels are kept in hardware, which covers an outer interrupt plus one nested interrupt with no software save. A further nested acknowledge sets a sticky overflow flag. A wake output is the plain OR of all requests whose priority is non-zero.

Top module: `ivc_top`

Register addresses use the 7-bit `bus_addr`:
- When bit 6 is 0, bits 5:0 select a source priority register. Data bits 3:0 hold the priority.
- 0x40 holds the routing word. Bit L set sends level L to the fast line.
- 0x41 is the acknowledge register (read).
- 0x42 is the end-of-interrupt register (write; the data is ignored).
- 0x43 is the status register. A read returns the current level in bits 3:0, the nesting depth in bits 5:4 and the overflow flag in bit 8. Any write to it clears the overflow flag.

Read data appears on `bus_rdata` at the clock edge that samples `bus_rd`.

## Requirements
- R1: A source priority written at address {0, idx} reads back unchanged. A source with priority 0 never drives either processor line, whatever its request does.
- R2: When a request wins, the next clock edge sets `irq_fast` if bit L of the routing word is 1 and `irq_norm` if it is 0, where L is the winner's level. The two lines are never high together.
- R3: A request counts as pending only if its priority is greater than the current masking level. When nothing is pending, both lines are low one edge later.
- R4: An acknowledge read returns the index of the pending source with the highest priority. Among sources tied at that priority, the lowest index wins.
- R5: An acknowledge read with nothing pending returns 64 and leaves the masking level and the depth unchanged.
- R6: An acknowledge read of a real source sets the masking level to that source's priority and adds one to the depth.
- R7: An end-of-interrupt write restores the most recently saved level and subtracts one from the depth. At depth 0 it changes nothing. Up to two levels are saved.
- R8: An acknowledge read at depth 2 still raises the masking level but saves nothing and sets status bit 8. Any write to the status register clears that bit.
- R9: `wake` is high whenever some request with non-zero priority is high, whatever the masking level.
- R10: After reset, all priorities are 0, the routing word is 0, the status is 0 and both processor lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 64 | Level-sensitive request per source |
| bus_addr | input | 7 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_fast | output | 1 | Fast processor interrupt line |
| irq_norm | output | 1 | Normal processor interrupt line |
| wake | output | 1 | OR of requests with non-zero priority |

## Verification
The overflow state is the hardest condition to reach from the ports. It needs three acknowledges in a row, each at a strictly higher priority, with every new request raised only after the previous acknowledge has lifted the mask. The bench builds this as a staircase of three sources at priorities 2, 5 and 8. It then unwinds the stack with end-of-interrupt writes and checks that the level lost to the overflow is not restored. A sweep over all fifteen non-zero levels covers routing, masking and restore for each level on its own.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int LVL_W   = 4;
  localparam int NUM_LVL = 1 << LVL_W;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    CTL_ROUTE = 2'd0,
    CTL_ACK   = 2'd1,
    CTL_EOI   = 2'd2,
    CTL_STAT  = 2'd3
  } ctl_sel_e;

  // Status word: overflow in bit 8, depth in bits 5:4, level in bits 3:0.
  function automatic logic [15:0] pack_status(lvl_t cur, logic [1:0] dep, logic ovf);
    return {7'b0, ovf, 2'b0, dep, cur};
  endfunction

  // True when a candidate is eligible against the current masking level.
  function automatic logic eligible(logic req, lvl_t prio, lvl_t cur);
    return req && (prio != '0) && (prio > cur);
  endfunction
endpackage

// File: rtl/ivc_cfg_regs.sv
module ivc_cfg_regs
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prio_we,
  input  logic [IDX_W-1:0]         prio_idx,
  input  lvl_t                     prio_wdata,
  input  logic                     route_we,
  input  logic [NUM_LVL-1:0]       route_wdata,
  output lvl_t [NUM_SRC-1:0]       prio_q,
  output logic [NUM_LVL-1:0]       fast_map
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
    end else if (prio_we) begin
      for (int s = 0; s < NUM_SRC; s++)
        if (prio_idx == IDX_W'(s)) prio_q[s] <= prio_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fast_map <= '0;
    else if (route_we) fast_map <= route_wdata;
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req,
  input  lvl_t [NUM_SRC-1:0] prio_q,
  input  lvl_t               cur_lvl,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);
  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible(req[i], prio_q[i], cur_lvl) && (prio_q[i] >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = prio_q[i];
      end
    end
  end
endmodule

// File: rtl/ivc_level_stack.sv
module ivc_level_stack
  import ivc_pkg::*;
#(
  parameter int STACK_D = 2,
  localparam int DEP_W = $clog2(STACK_D + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  lvl_t             push_lvl,
  input  logic             pop,
  input  logic             clr_ovf,
  output lvl_t             cur_lvl,
  output logic [DEP_W-1:0] depth,
  output logic             ovf
);
  lvl_t stk [STACK_D];
  lvl_t top_val;
  logic full;

  assign full = (depth == DEP_W'(STACK_D));

  always_comb begin
    top_val = '0;
    for (int g = 0; g < STACK_D; g++)
      if (depth == DEP_W'(g + 1)) top_val = stk[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < STACK_D; g++) stk[g] <= '0;
      cur_lvl <= '0;
      depth   <= '0;
      ovf     <= 1'b0;
    end else begin
      if (clr_ovf) ovf <= 1'b0;
      if (push) begin
        cur_lvl <= push_lvl;
        if (full) begin
          ovf <= 1'b1;
        end else begin
          for (int g = 0; g < STACK_D; g++)
            if (depth == DEP_W'(g)) stk[g] <= cur_lvl;
          depth <= depth + DEP_W'(1);
        end
      end else if (pop && depth != '0) begin
        cur_lvl <= top_val;
        depth   <= depth - DEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int STACK_D = 2,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = IDX_W + 1,
  localparam int DEP_W  = $clog2(STACK_D + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  output logic               irq_fast,
  output logic               irq_norm,
  output logic               wake
);
  lvl_t [NUM_SRC-1:0] prio_q;
  logic [NUM_LVL-1:0] fast_map;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  lvl_t               cur_lvl;
  logic [DEP_W-1:0]   depth;
  logic               ovf;

  logic               is_ctl;
  ctl_sel_e           ctl;
  logic               ack_fire, ack_take, eoi_fire, stat_clr;
  logic [NUM_SRC-1:0] live_req;

  assign is_ctl   = bus_addr[ADDR_W-1];
  assign ctl      = ctl_sel_e'(bus_addr[1:0]);
  assign ack_fire = bus_rd && is_ctl && (ctl == CTL_ACK);
  assign ack_take = ack_fire && win_valid;
  assign eoi_fire = bus_wr && is_ctl && (ctl == CTL_EOI);
  assign stat_clr = bus_wr && is_ctl && (ctl == CTL_STAT);

  ivc_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .prio_we     (bus_wr && !is_ctl),
    .prio_idx    (bus_addr[IDX_W-1:0]),
    .prio_wdata  (lvl_t'(bus_wdata[LVL_W-1:0])),
    .route_we    (bus_wr && is_ctl && (ctl == CTL_ROUTE)),
    .route_wdata (bus_wdata[NUM_LVL-1:0]),
    .prio_q      (prio_q),
    .fast_map    (fast_map)
  );

  ivc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .req       (irq_req),
    .prio_q    (prio_q),
    .cur_lvl   (cur_lvl),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  ivc_level_stack #(.STACK_D(STACK_D)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack_take),
    .push_lvl (win_lvl),
    .pop      (eoi_fire),
    .clr_ovf  (stat_clr),
    .cur_lvl  (cur_lvl),
    .depth    (depth),
    .ovf      (ovf)
  );

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_live
      assign live_req[s] = irq_req[s] && (prio_q[s] != '0);
    end
  endgenerate
  assign wake = |live_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_fast <= 1'b0;
      irq_norm <= 1'b0;
    end else begin
      irq_fast <= win_valid &&  fast_map[win_lvl];
      irq_norm <= win_valid && !fast_map[win_lvl];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (!is_ctl) begin
        bus_rdata <= 16'(prio_q[bus_addr[IDX_W-1:0]]);
      end else begin
        case (ctl)
          CTL_ROUTE: bus_rdata <= 16'(fast_map);
          CTL_ACK:   bus_rdata <= win_valid ? 16'(win_idx) : 16'(NUM_SRC);
          CTL_STAT:  bus_rdata <= pack_status(cur_lvl, 2'(depth), ovf);
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int STACK_D = 2,
  localparam int DEP_W = $clog2(STACK_D + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_fast,
  input logic               irq_norm,
  input logic               win_valid,
  input lvl_t               win_lvl,
  input lvl_t               cur_lvl,
  input logic [NUM_LVL-1:0] fast_map,
  input logic               ack_fire,
  input logic               ack_take,
  input logic               eoi_fire,
  input logic [DEP_W-1:0]   depth,
  input logic               ovf
);
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_fast && irq_norm));

  p_route_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && fast_map[win_lvl]) |=> irq_fast);

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |=> (!irq_fast && !irq_norm));

  p_above_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_lvl > cur_lvl));

  p_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !win_valid && !eoi_fire) |=> ($stable(cur_lvl) && $stable(depth)));

  p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (cur_lvl == $past(win_lvl)));

  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !ack_fire && depth != '0) |=> (depth == $past(depth) - DEP_W'(1)));

  p_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && depth == DEP_W'(STACK_D)) |=> ovf);
endmodule

bind ivc_top ivc_checker #(.STACK_D(STACK_D)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_fast  (irq_fast),
  .irq_norm  (irq_norm),
  .win_valid (win_valid),
  .win_lvl   (win_lvl),
  .cur_lvl   (cur_lvl),
  .fast_map  (fast_map),
  .ack_fire  (ack_fire),
  .ack_take  (ack_take),
  .eoi_fire  (eoi_fire),
  .depth     (depth),
  .ovf       (ovf)
);

// File: tb/test_ivc_top.sv
module test_ivc_top;
  localparam int NS = 64;
  localparam logic [6:0] A_ROUTE = 7'h40;
  localparam logic [6:0] A_ACK   = 7'h41;
  localparam logic [6:0] A_EOI   = 7'h42;
  localparam logic [6:0] A_STAT  = 7'h43;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic [6:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic          irq_fast, irq_norm, wake;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ivc_top i_ivc_top (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_fast(irq_fast), .irq_norm(irq_norm), .wake(wake)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output int d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = int'(bus_rdata);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic int stat_word(int cur, int dep, int ov);
    return cur + dep * 16 + ov * 256;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R10 reset state
    chk("R10 irq_fast", int'(irq_fast), 0);
    chk("R10 irq_norm", int'(irq_norm), 0);
    rd(A_STAT, v);  chk("R10 status", v, 0);
    rd(A_ROUTE, v); chk("R10 route", v, 0);
    rd(7'd5, v);    chk("R10 prio", v, 0);

    // R1 readback sweep over every source
    for (int i = 0; i < NS; i++) wr(7'(i), 16'((i * 7) % 16));
    for (int i = 0; i < NS; i++) begin
      rd(7'(i), v); chk("R1 readback", v, (i * 7) % 16);
    end
    for (int i = 0; i < NS; i++) wr(7'(i), 16'd0);

    // R1/R9/R5: all requests with priority 0
    irq_req = '1;
    settle();
    chk("R1 disabled fast", int'(irq_fast), 0);
    chk("R1 disabled norm", int'(irq_norm), 0);
    chk("R9 wake off", int'(wake), 0);
    rd(A_ACK, v);  chk("R5 spurious vec", v, NS);
    rd(A_STAT, v); chk("R5 status kept", v, 0);
    irq_req = '0;

    // R2/R3/R4/R6/R7 sweep over levels, odd levels routed fast
    wr(A_ROUTE, 16'hAAAA);
    for (int l = 1; l < 16; l++) begin
      int s;
      s = (l * 11) % NS;
      wr(7'(s), 16'(l));
      irq_req = '0; irq_req[s] = 1'b1;
      settle();
      chk("R2 fast line", int'(irq_fast), l % 2);
      chk("R2 normal line", int'(irq_norm), 1 - (l % 2));
      chk("R9 wake on", int'(wake), 1);
      rd(A_ACK, v);  chk("R4 vector", v, s);
      rd(A_STAT, v); chk("R6 level raised", v, stat_word(l, 1, 0));
      settle();
      chk("R3 masked", int'(irq_fast | irq_norm), 0);
      wr(A_EOI, 16'd0);
      rd(A_STAT, v); chk("R7 restored", v, 0);
      settle();
      chk("R3 unmasked again", int'(irq_fast | irq_norm), 1);
      wr(7'(s), 16'd0);
      irq_req = '0;
    end

    // R4 highest level then lowest index on tie; R5 while masked
    wr(7'd10, 16'd9); wr(7'd20, 16'd9); wr(7'd30, 16'd9);
    wr(7'd40, 16'd3); wr(7'd50, 16'd12);
    irq_req = '0;
    irq_req[10] = 1'b1; irq_req[20] = 1'b1; irq_req[30] = 1'b1;
    irq_req[40] = 1'b1; irq_req[50] = 1'b1;
    settle();
    rd(A_ACK, v);  chk("R4 highest level", v, 50);
    rd(A_ACK, v);  chk("R5 spurious masked", v, NS);
    rd(A_STAT, v); chk("R5 level kept", v, stat_word(12, 1, 0));
    wr(A_EOI, 16'd0);
    irq_req[50] = 1'b0;
    rd(A_ACK, v);  chk("R4 tie lowest", v, 10);
    wr(A_EOI, 16'd0);
    irq_req[10] = 1'b0;
    rd(A_ACK, v);  chk("R4 tie next", v, 20);
    wr(A_EOI, 16'd0);
    for (int i = 10; i <= 50; i += 10) wr(7'(i), 16'd0);
    irq_req = '0;

    // R7/R8 nesting staircase
    wr(7'd1, 16'd2); wr(7'd2, 16'd5); wr(7'd3, 16'd8);
    irq_req[1] = 1'b1;
    rd(A_ACK, v);  chk("R6 outer vec", v, 1);
    irq_req[2] = 1'b1;
    settle();
    chk("R3 nested visible", int'(irq_fast | irq_norm), 1);
    rd(A_ACK, v);  chk("R6 nested vec", v, 2);
    rd(A_STAT, v); chk("R7 depth two", v, stat_word(5, 2, 0));
    irq_req[3] = 1'b1;
    rd(A_ACK, v);  chk("R8 third vec", v, 3);
    rd(A_STAT, v); chk("R8 overflow set", v, stat_word(8, 2, 1));
    wr(A_EOI, 16'd0);
    rd(A_STAT, v); chk("R7 pop to outer", v, stat_word(2, 1, 1));
    wr(A_EOI, 16'd0);
    rd(A_STAT, v); chk("R7 pop to zero", v, stat_word(0, 0, 1));
    wr(A_EOI, 16'd0);
    rd(A_STAT, v); chk("R7 empty eoi", v, stat_word(0, 0, 1));
    wr(A_STAT, 16'd0);
    rd(A_STAT, v); chk("R8 overflow clear", v, 0);
    for (int i = 1; i <= 3; i++) wr(7'(i), 16'd0);
    irq_req = '0;

    // R9 wake ignores masking
    wr(7'd0, 16'd15); wr(7'd63, 16'd1);
    irq_req[0] = 1'b1;
    rd(A_ACK, v); chk("R4 src0", v, 0);
    irq_req = '0; irq_req[63] = 1'b1;
    settle();
    chk("R3 low masked", int'(irq_fast | irq_norm), 0);
    chk("R9 wake masked", int'(wake), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule